// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small processor core: a packed status word made of a current status byte, a saved status byte and a separately kept condition flag; a second-level saved status byte; two saved program counters; two general-purpose scratch words; and an interrupt-level and a user-level stack pointer. One combinational read port and one synchronous write port address the registers by control register number.

The two stack pointers are banked against the general-purpose stack pointer register, which lives in the general register file outside this block. Bit 7 of the status byte, the stack-mode flag, decides which of the two stack pointers is currently live in that general register. The other one is held locally. A side port reads the general stack pointer and can overwrite it. Accesses to the live stack pointer are redirected through that port. A status write that flips the stack-mode flag exchanges the live and banked pointers in the same clock edge.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every stored register is zero, the stack-mode output is 0, and every register number reads as zero, except number 2. Number 2 returns `sp_rd_data`, which is 0 when the external pointer is reset.
- R2: Reading number 0 (status) returns `{saved_byte & 8'hC1, cur_byte & 8'hC0}` in bits 15:0, with the condition flag placed in bit 0. All other bits read as zero.
- R3: A write to number 0 loads bits 15:8 into the saved status byte and bits 7:0 into the current status byte. It also loads bit 0 into the condition flag.
- R4: The `stack_mode` output equals bit 7 of the current status byte. It changes only on a write to number 0.
- R5: A status write that moves stack mode from 0 to 1 does two things in that cycle. It stores the value on `sp_rd_data` into the interrupt bank. It drives the user bank onto `sp_wr_data` with `sp_wr_en` high.
- R6: A status write that moves stack mode from 1 to 0 does two things in that cycle. It stores `sp_rd_data` into the user bank. It drives the interrupt bank onto `sp_wr_data` with `sp_wr_en` high.
- R7: Number 2 (interrupt stack pointer) reads and writes the general stack pointer through the side port when stack mode is 0, and the local bank when it is 1. Number 3 (user stack pointer) does the reverse.
- R8: Numbers 6 and 9 (saved program counters) store all 32 written bits and always read with bit 0 cleared.
- R9: Number 8 (second-level saved status) stores bits 7:0 and reads back that byte ANDed with 8'hC1. Number 1 (condition) writes and reads only bit 0, which is the same flag seen in bit 0 of the status read.
- R10: Numbers 4 and 5 are plain 32-bit storage that read back exactly what was written.
- R11: Any other number reads as zero. A write to such a number changes no register, no stack mode and no general stack pointer.
- R12: A read of a register in the same cycle as a write to it returns the value held before that write.
- R13: `sp_wr_en` rises only for a write to the live stack pointer or a status write that changes stack mode. A status write that keeps stack mode leaves the general stack pointer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_num | input | ADDR_W | Control register number to read |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_num | input | ADDR_W | Control register number to write |
| wr_data | input | 32 | Write data |
| sp_rd_data | input | 32 | Current value of the general stack pointer register |
| sp_wr_en | output | 1 | Write enable to the general stack pointer register |
| sp_wr_data | output | 32 | Value to load into the general stack pointer register |
| stack_mode | output | 1 | Current stack-mode flag |

## Verification
The bench models the external general stack pointer register and walks the stack-mode flag through both transitions. After each transition it checks the live pointer and both banked reads. A design that swapped in the wrong direction, or saved after loading, would hand back a stale pointer. The bench also writes the status word with stack mode unchanged. A design that swapped on every status write would corrupt the live pointer there.

Further directed cases cover the following:
- status-byte bits outside 0xC1/0xC0, which must stay hidden;
- odd values written to the saved program counters;
- the condition flag shared between two register numbers;
- a read and a write to the same register in one cycle, which must return the old value;
- writes to unmapped numbers, which must leave every mapped register and the general stack pointer unchanged.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int DATA_W = 32;

  localparam int CR_STATUS = 0;
  localparam int CR_COND   = 1;
  localparam int CR_ISP    = 2;
  localparam int CR_USP    = 3;
  localparam int CR_SAVPC  = 6;
  localparam int CR_SAVST2 = 8;
  localparam int CR_SAVPC2 = 9;

  localparam logic [7:0] SAVED_KEEP = 8'hC1;
  localparam logic [7:0] CUR_KEEP   = 8'hC0;
  localparam int         SM_BIT     = 7;

  localparam int PLAIN_CNT = 4;
  localparam int PLAIN_NUM [PLAIN_CNT] = '{4, 5, CR_SAVPC, CR_SAVPC2};
  localparam logic [DATA_W-1:0] PLAIN_MASK [PLAIN_CNT] =
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFE};
endpackage

// File: rtl/cr_word_reg.sv
module cr_word_reg
  import cr_pkg::*;
#(
  parameter logic [DATA_W-1:0] READ_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we) val_d = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (we) val_q <= val_d;
  end

  assign rd = val_q & READ_MASK;
endmodule

// File: rtl/cr_status_unit.sv
module cr_status_unit
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_status,
  input  logic              wr_cond,
  input  logic              wr_savst2,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status_rd,
  output logic [DATA_W-1:0] cond_rd,
  output logic [DATA_W-1:0] savst2_rd,
  output logic              sm
);
  logic [7:0] cur_q, cur_d;
  logic [7:0] sav_q, sav_d;
  logic [7:0] sav2_q, sav2_d;
  logic       cond_q, cond_d;
  logic       byte_en, cond_en, sav2_en;

  always_comb begin
    byte_en = wr_status;
    cond_en = wr_status | wr_cond;
    sav2_en = wr_savst2;
    cur_d   = wr_data[7:0];
    sav_d   = wr_data[15:8];
    sav2_d  = wr_data[7:0];
    cond_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      sav_q  <= '0;
      sav2_q <= '0;
      cond_q <= 1'b0;
    end else begin
      if (byte_en) begin
        cur_q <= cur_d;
        sav_q <= sav_d;
      end
      if (cond_en) cond_q <= cond_d;
      if (sav2_en) sav2_q <= sav2_d;
    end
  end

  assign status_rd = {16'h0, sav_q & SAVED_KEEP, (cur_q & CUR_KEEP) | {7'h0, cond_q}};
  assign cond_rd   = {31'h0, cond_q};
  assign savst2_rd = {24'h0, sav2_q & SAVED_KEEP};
  assign sm        = cur_q[SM_BIT];

  AST_COND_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond && !wr_status) |=> (cond_rd[0] == $past(wr_data[0]))); // R9
  AST_SAVED_BYTE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> (status_rd[15:8] == ($past(wr_data[15:8]) & SAVED_KEEP))); // R3
endmodule

// File: rtl/cr_stack_bank.sv
module cr_stack_bank
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sm,
  input  logic              swap,
  input  logic              wr_isp,
  input  logic              wr_usp,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sp_in,
  output logic [DATA_W-1:0] isp_rd,
  output logic [DATA_W-1:0] usp_rd,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_wd
);
  logic [DATA_W-1:0] isp_q, isp_d;
  logic [DATA_W-1:0] usp_q, usp_d;
  logic              isp_en, usp_en;

  always_comb begin
    isp_en = 1'b0;
    usp_en = 1'b0;
    isp_d  = isp_q;
    usp_d  = usp_q;
    sp_we  = 1'b0;
    sp_wd  = '0;
    if (swap) begin
      sp_we = 1'b1;
      if (sm) begin
        usp_en = 1'b1;
        usp_d  = sp_in;
        sp_wd  = isp_q;
      end else begin
        isp_en = 1'b1;
        isp_d  = sp_in;
        sp_wd  = usp_q;
      end
    end
    if (wr_isp) begin
      if (sm) begin
        isp_en = 1'b1;
        isp_d  = wr_data;
      end else begin
        sp_we = 1'b1;
        sp_wd = wr_data;
      end
    end
    if (wr_usp) begin
      if (sm) begin
        sp_we = 1'b1;
        sp_wd = wr_data;
      end else begin
        usp_en = 1'b1;
        usp_d  = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      if (isp_en) isp_q <= isp_d;
      if (usp_en) usp_q <= usp_d;
    end
  end

  assign isp_rd = sm ? isp_q : sp_in;
  assign usp_rd = sm ? sp_in : usp_q;

  AST_ENTER_SM_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !sm) |=> (isp_rd == $past(sp_in))); // R5
  AST_LEAVE_SM_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && sm) |=> (usp_rd == $past(sp_in))); // R6
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import cr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_num,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_num,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       sp_rd_data,
  output logic              sp_wr_en,
  output logic [31:0]       sp_wr_data,
  output logic              stack_mode
);
  logic              hit_status, hit_cond, hit_isp, hit_usp, hit_savst2;
  logic              swap;
  logic [DATA_W-1:0] status_rd, cond_rd, savst2_rd, isp_rd, usp_rd;
  logic [DATA_W-1:0] plain_rd [PLAIN_CNT];

  assign hit_status = wr_en && (wr_num == ADDR_W'(CR_STATUS));
  assign hit_cond   = wr_en && (wr_num == ADDR_W'(CR_COND));
  assign hit_isp    = wr_en && (wr_num == ADDR_W'(CR_ISP));
  assign hit_usp    = wr_en && (wr_num == ADDR_W'(CR_USP));
  assign hit_savst2 = wr_en && (wr_num == ADDR_W'(CR_SAVST2));
  assign swap       = hit_status && (wr_data[SM_BIT] != stack_mode);

  cr_status_unit u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_status (hit_status),
    .wr_cond   (hit_cond),
    .wr_savst2 (hit_savst2),
    .wr_data   (wr_data),
    .status_rd (status_rd),
    .cond_rd   (cond_rd),
    .savst2_rd (savst2_rd),
    .sm        (stack_mode)
  );

  cr_stack_bank u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .sm      (stack_mode),
    .swap    (swap),
    .wr_isp  (hit_isp),
    .wr_usp  (hit_usp),
    .wr_data (wr_data),
    .sp_in   (sp_rd_data),
    .isp_rd  (isp_rd),
    .usp_rd  (usp_rd),
    .sp_we   (sp_wr_en),
    .sp_wd   (sp_wr_data)
  );

  for (genvar g = 0; g < PLAIN_CNT; g++) begin : g_plain
    logic plain_we;
    assign plain_we = wr_en && (wr_num == ADDR_W'(PLAIN_NUM[g]));
    cr_word_reg #(.READ_MASK(PLAIN_MASK[g])) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (plain_we),
      .wd    (wr_data),
      .rd    (plain_rd[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if      (rd_num == ADDR_W'(CR_STATUS)) rd_data = status_rd;
    else if (rd_num == ADDR_W'(CR_COND))   rd_data = cond_rd;
    else if (rd_num == ADDR_W'(CR_ISP))    rd_data = isp_rd;
    else if (rd_num == ADDR_W'(CR_USP))    rd_data = usp_rd;
    else if (rd_num == ADDR_W'(CR_SAVST2)) rd_data = savst2_rd;
    else begin
      for (int i = 0; i < PLAIN_CNT; i++)
        if (rd_num == ADDR_W'(PLAIN_NUM[i])) rd_data = plain_rd[i];
    end
  end

  AST_SM_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_status |=> (stack_mode == $past(wr_data[SM_BIT]))); // R4
  AST_SM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_status |=> $stable(stack_mode)); // R4
  AST_SAVPC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_num == ADDR_W'(CR_SAVPC)) || (rd_num == ADDR_W'(CR_SAVPC2))) |-> !rd_data[0]); // R8
  AST_STATUS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num == ADDR_W'(CR_STATUS)) |-> ((rd_data & ~32'h0000_C1C1) == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_num == ADDR_W'(7)) || (rd_num > ADDR_W'(CR_SAVPC2))) |-> (rd_data == '0)); // R11
  AST_SP_WRITE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> (wr_en && (hit_status || hit_isp || hit_usp))); // R13
endmodule

// File: tb/ctrl_reg_bank_test.sv
`timescale 1ns/1ps
module ctrl_reg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_num;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [4:0]  wr_num;
  logic [31:0] wr_data;
  logic [31:0] sp_reg;
  logic        sp_wr_en;
  logic [31:0] sp_wr_data;
  logic        stack_mode;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  ctrl_reg_bank #(.ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .rd_num(rd_num), .rd_data(rd_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .sp_rd_data(sp_reg), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .stack_mode(stack_mode)
  );

  // external general stack pointer register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sp_reg <= '0;
    else if (sp_wr_en) sp_reg <= sp_wr_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = n; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] n, input logic [31:0] exp);
    @(negedge clk);
    rd_num = n;
    #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    for (int n = 0; n < 16; n++) rd_chk("R1", 5'(n), 32'h0);
    chk("R1 stack_mode", {31'h0, stack_mode}, 32'h0);
  endtask

  task automatic t_route_sm0;
    wr(5'd2, 32'h0000_1000);
    chk("R7 isp live", sp_reg, 32'h0000_1000);
    rd_chk("R7", 5'd2, 32'h0000_1000);
    wr(5'd3, 32'h0000_2000);
    chk("R13 usp banked", sp_reg, 32'h0000_1000);
    rd_chk("R7", 5'd3, 32'h0000_2000);
  endtask

  task automatic t_enter_sm;
    wr(5'd0, 32'h0000_0080);
    chk("R4 sm", {31'h0, stack_mode}, 32'h1);
    chk("R5 live=usp", sp_reg, 32'h0000_2000);
    rd_chk("R5 isp saved", 5'd2, 32'h0000_1000);
    rd_chk("R5 usp live", 5'd3, 32'h0000_2000);
    rd_chk("R2", 5'd0, 32'h0000_0080);
  endtask

  task automatic t_status_keep_sm;
    wr(5'd0, 32'hFFFF_4281);
    rd_chk("R2 R3", 5'd0, 32'h0000_4081);
    chk("R13 no swap", sp_reg, 32'h0000_2000);
    chk("R4 sm kept", {31'h0, stack_mode}, 32'h1);
  endtask

  task automatic t_route_sm1;
    wr(5'd3, 32'h0000_3000);
    chk("R7 usp live", sp_reg, 32'h0000_3000);
    wr(5'd2, 32'h0000_4000);
    chk("R7 isp banked", sp_reg, 32'h0000_3000);
    rd_chk("R7", 5'd2, 32'h0000_4000);
    rd_chk("R7", 5'd3, 32'h0000_3000);
  endtask

  task automatic t_leave_sm;
    wr(5'd0, 32'h0000_FF7E);
    chk("R4 sm", {31'h0, stack_mode}, 32'h0);
    chk("R6 live=isp", sp_reg, 32'h0000_4000);
    rd_chk("R6 usp saved", 5'd3, 32'h0000_3000);
    rd_chk("R6 isp live", 5'd2, 32'h0000_4000);
    rd_chk("R2 R3", 5'd0, 32'h0000_C140);
  endtask

  task automatic t_read_during_write;
    @(negedge clk);
    rd_num = 5'd6; wr_en = 1'b1; wr_num = 5'd6; wr_data = 32'h0000_1235;
    #0.5;
    chk("R12 old value", rd_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
    chk("R8 new value", rd_data, 32'h0000_1234);
  endtask

  task automatic t_savpc;
    wr(5'd9, 32'hFFFF_FFFF);
    rd_chk("R8", 5'd9, 32'hFFFF_FFFE);
    wr(5'd6, 32'h8765_4320);
    rd_chk("R8", 5'd6, 32'h8765_4320);
  endtask

  task automatic t_cond_savst2;
    wr(5'd8, 32'hFFFF_FFFF);
    rd_chk("R9", 5'd8, 32'h0000_00C1);
    wr(5'd1, 32'hFFFF_FFFE);
    rd_chk("R9", 5'd1, 32'h0);
    wr(5'd1, 32'h0000_0003);
    rd_chk("R9", 5'd1, 32'h1);
    rd_chk("R9 shared flag", 5'd0, 32'h0000_C141);
  endtask

  task automatic t_scratch;
    wr(5'd4, 32'hDEAD_BEEF);
    wr(5'd5, 32'h0BAD_F00D);
    rd_chk("R10", 5'd4, 32'hDEAD_BEEF);
    rd_chk("R10", 5'd5, 32'h0BAD_F00D);
  endtask

  task automatic t_unmapped;
    wr(5'd7, 32'hFFFF_FFFF);
    wr(5'd12, 32'hFFFF_FFFF);
    wr(5'd31, 32'hFFFF_FFFF);
    rd_chk("R11", 5'd7, 32'h0);
    rd_chk("R11", 5'd12, 32'h0);
    rd_chk("R11 status", 5'd0, 32'h0000_C141);
    rd_chk("R11 isp", 5'd2, 32'h0000_4000);
    rd_chk("R11 usp", 5'd3, 32'h0000_3000);
    rd_chk("R11 scratch", 5'd4, 32'hDEAD_BEEF);
    rd_chk("R11 savst2", 5'd8, 32'h0000_00C1);
    chk("R11 sp", sp_reg, 32'h0000_4000);
    chk("R11 sm", {31'h0, stack_mode}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_num = '0; wr_data = '0; rd_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route_sm0();
    t_enter_sm();
    t_status_keep_sm();
    t_route_sm1();
    t_leave_sm();
    t_read_during_write();
    t_savpc();
    t_cond_savst2();
    t_scratch();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule